// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block owns the SDRAM command pins from reset until the memory can accept traffic. It first holds the bus at NOP for the power-up pause. It then closes every bank with one precharge-all and runs a fixed number of auto-refresh cycles. Last, it loads the mode register with a parameter word that holds burst length, burst type and CAS latency. A ready flag rises once the mode-load settling time has passed. All delays are parameters counted in clock cycles.

After initialization, a free-running interval counter marks each refresh deadline. At each deadline the sequencer raises a request to the access engine. Once it sees the grant, it closes all banks and issues an auto-refresh. It then holds the bus for a full row cycle before releasing it. If the request is still waiting when a second deadline passes, the sequencer pays back the debt with two auto-refreshes back to back. A self-refresh input uses the same handshake. The sequencer closes the banks and drops CKE together with a refresh command. When the input falls, it raises CKE again. It keeps the bus for two clocks plus a row cycle before handing it back.

Top module: `sdr_init_refresh`

## Requirements
- R1: While reset is high, the command pins {cs_n,ras_n,cas_n,we_n} read NOP (0111), cke is high, and ready and ref_req are low.
- R2: After reset falls, the pins show only NOP until the first command. That command is a precharge (0010) with address bit 10 high (all banks). It appears T_PWRUP cycles after the first clock edge following reset.
- R3: After that precharge come INIT_REFS auto-refresh commands (0001). The first comes T_RP cycles after the precharge, and each later one comes T_RC cycles after the one before.
- R4: A mode register load (0000) follows T_RC cycles after the last initial refresh. It carries the mode word on address bits 6:0 (bits 2:0 burst length code, bit 3 interleave, bits 6:4 CAS latency), with all other address bits and the bank bits zero.
- R5: ready rises T_RSC cycles after the mode register load and never falls afterwards.
- R6: ref_req first rises T_REFI+1 cycles after ready rises. Later requests rise every T_REFI cycles. Once a request is granted, the block issues a precharge-all, then an auto-refresh T_RP cycles later, then drops ref_req T_RC cycles after that refresh. Only NOP appears in between.
- R7: If a second refresh interval elapses before the grant arrives, the service issues two auto-refreshes T_RC apart before releasing the bus.
- R8: Once ready is high, any command other than NOP appears only while ref_req and ref_gnt are both high.
- R9: If sr_req is high when a grant is taken, the block issues a precharge-all. T_RP cycles later it issues an auto-refresh with cke driven low in the same cycle. cke then stays low, ref_req stays high and the pins show NOP for as long as sr_req stays high.
- R10: The cycle after sr_req falls, cke returns high. ref_req then falls 2+T_RC cycles after cke rose, with only NOP in between. Periodic requests then resume T_REFI+1 cycles after the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_gnt | input | 1 | Bus grant from the access engine |
| sr_req | input | 1 | Request to enter and hold self-refresh |
| ready | output | 1 | Memory initialized and usable |
| ref_req | output | 1 | Sequencer needs or holds the command bus |
| cke | output | 1 | SDRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address pins (all-bank flag, mode word) |
| ba | output | 2 | Bank select pins |

## Verification
The checks assume that the access engine raises ref_gnt only while ref_req is high and holds it high until ref_req falls. The bus-ownership property relies on the grant having been seen one cycle before each command. The bench's grant responder follows this rule: it raises the grant a programmable number of cycles after the request and drops it as soon as the request falls. sr_req is raised only after ready and only at a release point, so every self-refresh entry starts from an idle sequencer.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } sdr_cmd_e;

    typedef struct packed {
        sdr_cmd_e cmd;
        logic     all_banks;
        logic     load_mode;
    } sdr_slot_t;

    typedef enum logic [3:0] {
        ST_POWERUP,
        ST_INIT_PRE_W,
        ST_INIT_REF_W,
        ST_MRS_W,
        ST_IDLE,
        ST_WAIT_GNT,
        ST_SVC_PRE_W,
        ST_SVC_REF_W,
        ST_SELF,
        ST_SELF_EXIT
    } seq_state_e;

    localparam int MR_BITS = 7;
    localparam int SREX_CYCLES = 2;
    localparam sdr_slot_t SLOT_IDLE = '{cmd: CMD_NOP, all_banks: 1'b0, load_mode: 1'b0};

    function automatic logic [MR_BITS-1:0] mode_word(input logic [2:0] bl_code,
                                                     input logic interleave,
                                                     input logic [2:0] cas_lat);
        return {cas_lat, interleave, bl_code};
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer #(
    parameter int T_REFI = 1560
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic take,
    output logic due,
    output logic missed
);
    localparam int CNT_W = $clog2(T_REFI + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [1:0]       debt_q;
    logic             expire;

    assign expire = (cnt_q == '0);
    assign due    = (debt_q != 2'd0);
    assign missed = (debt_q == 2'd2);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q  <= CNT_W'(T_REFI - 1);
            debt_q <= 2'd0;
        end else begin
            cnt_q <= expire ? CNT_W'(T_REFI - 1) : cnt_q - 1'b1;
            if (take)
                debt_q <= expire ? 2'd1 : 2'd0;
            else if (expire && debt_q != 2'd2)
                debt_q <= debt_q + 2'd1;
        end
    end

    // R6
    due_from_expiry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(due) |-> $past(cnt_q == '0));

    // R7
    debt_capped_chk: assert property (@(posedge clk) disable iff (rst)
        debt_q != 2'd3);

endmodule

// File: rtl/sdr_pin_decode.sv
module sdr_pin_decode
    import sdr_seq_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter logic [MR_BITS-1:0] MODE_REG = '0
) (
    input  sdr_slot_t         slot,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [1:0]        ba
);
    localparam logic [ADDR_W-1:0] ALL_BANK_A = ADDR_W'(1) << 10;

    always_comb begin
        {cs_n, ras_n, cas_n, we_n} = slot.cmd;
        if (slot.load_mode)
            addr = ADDR_W'(MODE_REG);
        else if (slot.all_banks)
            addr = ALL_BANK_A;
        else
            addr = '0;
        ba = 2'b00;
    end

endmodule

// File: rtl/sdr_init_refresh.sv
module sdr_init_refresh
    import sdr_seq_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int T_PWRUP   = 20000,
    parameter int T_RP      = 4,
    parameter int T_RC      = 14,
    parameter int T_RSC     = 2,
    parameter int T_REFI    = 1560,
    parameter int INIT_REFS = 8,
    parameter logic [MR_BITS-1:0] MODE_REG = mode_word(3'b011, 1'b0, 3'd3)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_gnt,
    input  logic              sr_req,
    output logic              ready,
    output logic              ref_req,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [1:0]        ba
);
    localparam int LONGEST = max_of(max_of(T_PWRUP, T_REFI),
                                    max_of(T_RC + SREX_CYCLES, max_of(T_RP, T_RSC)));
    localparam int WAIT_W  = $clog2(LONGEST + 1);
    localparam int NREF_W  = $clog2(INIT_REFS + 1);

    localparam sdr_slot_t SLOT_PRE = '{cmd: CMD_PRE, all_banks: 1'b1, load_mode: 1'b0};
    localparam sdr_slot_t SLOT_REF = '{cmd: CMD_REF, all_banks: 1'b0, load_mode: 1'b0};
    localparam sdr_slot_t SLOT_MRS = '{cmd: CMD_MRS, all_banks: 1'b0, load_mode: 1'b1};

    seq_state_e        state_q;
    sdr_slot_t         slot_q;
    logic [WAIT_W-1:0] wait_q;
    logic [NREF_W-1:0] refs_left_q;
    logic              sr_mode_q;
    logic              double_q;
    logic              take;
    logic              due;
    logic              missed;
    logic              timer_run;
    logic              wait_done;

    assign take      = (state_q == ST_WAIT_GNT) && ref_gnt;
    assign timer_run = ready && !sr_mode_q;
    assign wait_done = (wait_q == '0);

    sdr_refresh_timer #(.T_REFI(T_REFI)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (timer_run),
        .take   (take),
        .due    (due),
        .missed (missed)
    );

    sdr_pin_decode #(.ADDR_W(ADDR_W), .MODE_REG(MODE_REG)) u_pins (
        .slot  (slot_q),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .addr  (addr),
        .ba    (ba)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_POWERUP;
            wait_q      <= WAIT_W'(T_PWRUP - 1);
            slot_q      <= SLOT_IDLE;
            cke         <= 1'b1;
            ready       <= 1'b0;
            ref_req     <= 1'b0;
            refs_left_q <= '0;
            sr_mode_q   <= 1'b0;
            double_q    <= 1'b0;
        end else begin
            slot_q <= SLOT_IDLE;
            if (!wait_done)
                wait_q <= wait_q - 1'b1;
            case (state_q)
                ST_POWERUP: if (wait_done) begin
                    slot_q  <= SLOT_PRE;
                    wait_q  <= WAIT_W'(T_RP - 1);
                    state_q <= ST_INIT_PRE_W;
                end
                ST_INIT_PRE_W: if (wait_done) begin
                    slot_q      <= SLOT_REF;
                    wait_q      <= WAIT_W'(T_RC - 1);
                    refs_left_q <= NREF_W'(INIT_REFS - 1);
                    state_q     <= ST_INIT_REF_W;
                end
                ST_INIT_REF_W: if (wait_done) begin
                    if (refs_left_q != '0) begin
                        slot_q      <= SLOT_REF;
                        wait_q      <= WAIT_W'(T_RC - 1);
                        refs_left_q <= refs_left_q - 1'b1;
                    end else begin
                        slot_q  <= SLOT_MRS;
                        wait_q  <= WAIT_W'(T_RSC - 1);
                        state_q <= ST_MRS_W;
                    end
                end
                ST_MRS_W: if (wait_done) begin
                    ready   <= 1'b1;
                    state_q <= ST_IDLE;
                end
                ST_IDLE: if (due || sr_req) begin
                    ref_req <= 1'b1;
                    state_q <= ST_WAIT_GNT;
                end
                ST_WAIT_GNT: if (ref_gnt) begin
                    sr_mode_q <= sr_req;
                    double_q  <= missed;
                    slot_q    <= SLOT_PRE;
                    wait_q    <= WAIT_W'(T_RP - 1);
                    state_q   <= ST_SVC_PRE_W;
                end
                ST_SVC_PRE_W: if (wait_done) begin
                    slot_q <= SLOT_REF;
                    if (sr_mode_q) begin
                        cke     <= 1'b0;
                        state_q <= ST_SELF;
                    end else begin
                        wait_q      <= WAIT_W'(T_RC - 1);
                        refs_left_q <= double_q ? NREF_W'(1) : '0;
                        state_q     <= ST_SVC_REF_W;
                    end
                end
                ST_SVC_REF_W: if (wait_done) begin
                    if (refs_left_q != '0) begin
                        slot_q      <= SLOT_REF;
                        wait_q      <= WAIT_W'(T_RC - 1);
                        refs_left_q <= refs_left_q - 1'b1;
                    end else begin
                        ref_req <= 1'b0;
                        state_q <= ST_IDLE;
                    end
                end
                ST_SELF: if (!sr_req) begin
                    cke     <= 1'b1;
                    wait_q  <= WAIT_W'(SREX_CYCLES + T_RC - 1);
                    state_q <= ST_SELF_EXIT;
                end
                ST_SELF_EXIT: if (wait_done) begin
                    ref_req   <= 1'b0;
                    sr_mode_q <= 1'b0;
                    state_q   <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Checker state: distance to, and kind of, the previous issued command
    logic [15:0] since_q;
    sdr_cmd_e    last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= 16'd0;
            last_q  <= CMD_NOP;
        end else if (slot_q.cmd != CMD_NOP) begin
            since_q <= 16'd1;
            last_q  <= slot_q.cmd;
        end else if (since_q != 16'hFFFF) begin
            since_q <= since_q + 16'd1;
        end
    end

    // R3
    gap_after_pre_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_q.cmd != CMD_NOP && last_q == CMD_PRE) |-> since_q >= 16'(T_RP));

    // R3
    gap_after_ref_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_q.cmd != CMD_NOP && last_q == CMD_REF) |-> since_q >= 16'(T_RC));

    // R5
    ready_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);

    // R8
    bus_owned_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && slot_q.cmd != CMD_NOP) |-> (ref_req && $past(ref_gnt)));

    // R9
    cke_low_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!cke && $past(!cke)) |-> (slot_q.cmd == CMD_NOP && ref_req));

    // R6
    req_held_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_req && !ref_gnt) |=> ref_req);

endmodule

// File: tb/sdr_init_refresh_test.sv
`timescale 1ns/1ps
module sdr_init_refresh_test;
    import sdr_seq_pkg::*;

    localparam int P_PWR  = 20;
    localparam int P_RP   = 3;
    localparam int P_RC   = 5;
    localparam int P_RSC  = 2;
    localparam int P_REFI = 40;
    localparam int P_NREF = 8;
    localparam logic [6:0] MODE = 7'b0110011;

    logic clk = 1'b0;
    logic rst, ref_gnt, sr_req;
    logic ready, ref_req, cke, cs_n, ras_n, cas_n, we_n;
    logic [12:0] addr;
    logic [1:0]  ba;
    logic [3:0]  cmd;

    assign cmd = {cs_n, ras_n, cas_n, we_n};

    always #2.5 clk = ~clk;

    sdr_init_refresh #(
        .ADDR_W(13), .T_PWRUP(P_PWR), .T_RP(P_RP), .T_RC(P_RC),
        .T_RSC(P_RSC), .T_REFI(P_REFI), .INIT_REFS(P_NREF), .MODE_REG(MODE)
    ) uut (
        .clk(clk), .rst(rst), .ref_gnt(ref_gnt), .sr_req(sr_req),
        .ready(ready), .ref_req(ref_req), .cke(cke),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .ba(ba)
    );

    int n_chk = 0, n_fail = 0;
    int cyc = 0, gnt_delay = 1, gnt_wait = 0;
    int bus_bad = 0, ready_drop = 0;
    bit ready_seen = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        cyc++;
        if (ready && cmd != 4'b0111 && !(ref_req && ref_gnt)) bus_bad++;
        if (ready) ready_seen = 1;
        if (ready_seen && !ready) ready_drop++;
        if (ref_req && !ref_gnt) begin
            gnt_wait++;
            if (gnt_wait >= gnt_delay) ref_gnt = 1'b1;
        end else if (!ref_req) begin
            ref_gnt  = 1'b0;
            gnt_wait = 0;
        end
    endtask

    task automatic next_cmd(output int gap);
        gap = 0;
        do begin
            step();
            gap++;
        end while (cmd == 4'b0111 && gap < 100000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int g, quiet, t1, t2;
        rst = 1'b1; sr_req = 1'b0; ref_gnt = 1'b0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(cmd == 4'b0111, "R1 cmd", cmd, 4'b0111);
        chk(cke && !ready && !ref_req, "R1 cke/ready/ref_req", {cke, ready, ref_req}, 3'b100);
        rst = 1'b0;

        // R2 power-up wait then precharge-all
        next_cmd(g);
        chk(g == P_PWR, "R2 pause", g, P_PWR);
        chk(cmd == 4'b0010 && addr[10], "R2 pre-all", {cmd, addr[10]}, 5'b00101);

        // R3 initial refresh train
        for (int i = 0; i < P_NREF; i++) begin
            next_cmd(g);
            chk(cmd == 4'b0001 && g == ((i == 0) ? P_RP : P_RC), "R3 init refresh gap", g,
                (i == 0) ? P_RP : P_RC);
        end

        // R4 mode register load
        next_cmd(g);
        chk(cmd == 4'b0000 && g == P_RC, "R4 mrs gap", g, P_RC);
        chk(addr == 13'(MODE) && ba == 2'b00, "R4 mode word", addr, MODE);

        // R5 ready after settling
        g = 0;
        do begin step(); g++; end while (!ready && g < 1000);
        chk(g == P_RSC, "R5 ready delay", g, P_RSC);

        // R6 first periodic request and service
        g = 0;
        do begin step(); g++; end while (!ref_req && g < 1000);
        chk(g == P_REFI + 1, "R6 first request", g, P_REFI + 1);
        t1 = cyc;
        next_cmd(g);
        chk(cmd == 4'b0010 && addr[10], "R6 service pre-all", cmd, 4'b0010);
        next_cmd(g);
        chk(cmd == 4'b0001 && g == P_RP, "R6 service refresh gap", g, P_RP);
        g = 0; quiet = 1;
        do begin step(); g++; if (cmd != 4'b0111) quiet = 0; end while (ref_req && g < 1000);
        chk(g == P_RC && quiet == 1, "R6 release after refresh", g, P_RC);

        // R7 missed deadline: grant held back past a second interval
        gnt_delay = P_REFI + 3;
        g = 0;
        do begin step(); g++; end while (!ref_req && g < 1000);
        t2 = cyc;
        chk(t2 - t1 == P_REFI, "R6 request period", t2 - t1, P_REFI);
        next_cmd(g);
        chk(cmd == 4'b0010, "R7 pre-all", cmd, 4'b0010);
        next_cmd(g);
        chk(cmd == 4'b0001 && g == P_RP, "R7 first refresh gap", g, P_RP);
        next_cmd(g);
        chk(cmd == 4'b0001 && g == P_RC, "R7 second refresh gap", g, P_RC);
        g = 0; quiet = 1;
        do begin step(); g++; if (cmd != 4'b0111) quiet = 0; end while (ref_req && g < 1000);
        chk(g == P_RC && quiet == 1, "R7 release after pair", g, P_RC);

        // R9 self-refresh entry
        gnt_delay = 1;
        sr_req = 1'b1;
        next_cmd(g);
        chk(cmd == 4'b0010 && addr[10], "R9 pre-all", cmd, 4'b0010);
        next_cmd(g);
        chk(cmd == 4'b0001 && g == P_RP && !cke, "R9 entry refresh with cke low", g, P_RP);
        quiet = 1;
        for (int i = 0; i < 30; i++) begin
            step();
            if (cmd != 4'b0111 || cke || !ref_req) quiet = 0;
        end
        chk(quiet == 1, "R9 held in self-refresh", quiet, 1);

        // R10 self-refresh exit
        sr_req = 1'b0;
        g = 0;
        do begin step(); g++; end while (!cke && g < 1000);
        chk(g == 1, "R10 cke rise", g, 1);
        g = 0; quiet = 1;
        do begin step(); g++; if (cmd != 4'b0111) quiet = 0; end while (ref_req && g < 1000);
        chk(g == 2 + P_RC && quiet == 1, "R10 exit window", g, 2 + P_RC);
        g = 0;
        do begin step(); g++; end while (!ref_req && g < 1000);
        chk(g == P_REFI + 1, "R10 refresh resumes", g, P_REFI + 1);

        // R5 / R8 running monitors
        chk(ready_drop == 0, "R5 ready sticky", ready_drop, 0);
        chk(bus_bad == 0, "R8 bus ownership", bus_bad, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule